// File: doc/BRIEF.md
# Panel Self-Refresh Sequencer

This block is the source-side sequencer for a display panel that holds its own copy of the frame. While the screen stays unchanged for a programmed number of frames, it walks the link into a low-power active state in which the panel refreshes itself. When software or a screen change asks for fresh pixels, it leads the link back out through an exit state that waits for the sink to acknowledge a wake write.

Software owns the enable and the active-entry request. The sequencer owns the timed moves: the one-frame static entry, the return from exit to inactive, and the single-frame update path. The single-frame update lets one new frame reach the panel without a full exit. Software sets the request before it alters the frame, and the request clears itself once the block is back in the plain active state.

The current state is reported as a three-bit code. The code values below are fixed because software decodes them.

Top module: `srf_ctrl`

## Requirements
- R1: `state_o` carries the code 0 = off, 1 = inactive, 2 = entering (static frame sent), 3 = active with link down, 4 = active with single-frame update, 5 = exit. After reset the code is 0 and every other output is low.
- R2: In state 0, `enable_i` high moves the state to 1 at the next edge. In state 1, `enable_i` low moves the state to 0 at the next edge.
- R3: In state 1, a `vblank_i` without `change_i` increments the idle count, and `change_i` clears it. The threshold is the larger of `idle_frames_i` and 6. With `entry_i` high, the state moves to 2 on the edge after the count has reached the threshold.
- R4: State 2 raises `in_trans_o`. It moves to 3 on a `vblank_i` that arrives without `change_i`, and a `vblank_i` that comes with `change_i` keeps it in 2.
- R5: State 3 raises `link_down_o` and `active_o`. Any of `change_i`, `entry_i` low or `enable_i` low moves it to 5.
- R6: Entering state 5 raises `wake_req_o` for exactly one cycle, and `in_trans_o` is high throughout state 5. The state holds at 5 until `wake_seen_i`, then moves to 1 with the idle count cleared.
- R7: `sfu_set_i` sets `sfu_pend_o`. In state 3 a pending request moves the state to 4, where `active_o` is high, `link_down_o` is low and `change_i` causes no exit. A `vblank_i` in state 4 returns the state to 3 and clears `sfu_pend_o`.
- R8: When `enable_i` is dropped in state 2, the entry completes first. The state then goes 3 to 5, waits for `wake_seen_i` to reach 1, and only then goes to 0.
- R9: When `sfu_set_i` and `change_i` arrive in the same cycle in state 3, the state moves to 5 and `sfu_pend_o` ends low.
- R10: `sfu_pend_o` is cleared on entry to state 0 or 5, and `sfu_set_i` is ignored in state 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Software enable |
| entry_i | input | 1 | Software active-entry request (level) |
| sfu_set_i | input | 1 | Single-frame update request pulse |
| vblank_i | input | 1 | Once-per-frame tick |
| change_i | input | 1 | Screen content changed |
| wake_seen_i | input | 1 | Sink wake write observed |
| idle_frames_i | input | IDLE_W | Requested idle frames before entry |
| state_o | output | 3 | Current state code |
| in_trans_o | output | 1 | In a transition state (2 or 5) |
| link_down_o | output | 1 | Link may power down |
| active_o | output | 1 | Self-refresh active (3 or 4) |
| sfu_pend_o | output | 1 | Single-frame update request pending |
| wake_req_o | output | 1 | One-cycle wake pulse toward the aux requester |

## Verification
In state 3, a single-frame update request and a screen change can land on the same clock edge. The request sets a flag and the change forces an exit, and the flag's clear has priority. The bench provokes this by pulsing both inputs in one cycle while the block is active. It expects code 5, a wake pulse and a low pending flag on the next cycle. A second overlap it exercises is a vblank carrying a change during entry, which must hold the state at 2.

// File: rtl/srf_pkg.sv
package srf_pkg;
  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_IDLE   = 3'd1,
    ST_ENTER  = 3'd2,
    ST_ACTIVE = 3'd3,
    ST_SINGLE = 3'd4,
    ST_EXIT   = 3'd5
  } srf_state_e;

  localparam int unsigned MIN_IDLE_FRAMES = 6;
endpackage

// File: rtl/srf_idle_cnt.sv
module srf_idle_cnt #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             count_en_i,
  input  logic             vblank_i,
  input  logic             chg_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic             met_o
);
  import srf_pkg::*;

  localparam logic [CNT_W-1:0] MIN_L = CNT_W'(MIN_IDLE_FRAMES);

  logic [CNT_W-1:0] thr_eff;
  logic [CNT_W-1:0] cnt_q;

  assign thr_eff = (thr_i < MIN_L) ? MIN_L : thr_i;
  assign met_o   = (cnt_q >= thr_eff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!count_en_i)      cnt_q <= '0;
    else if (chg_i)            cnt_q <= '0;
    else if (vblank_i && !met_o) cnt_q <= cnt_q + 1'b1;
  end

  // R3: without a tick or change the entry condition cannot move
  assert_met_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_en_i && !vblank_i && !chg_i) |=> (met_o == $past(met_o) || !$stable(thr_i)));

  // R3: a change always drops the condition
  assert_chg_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg_i && count_en_i) |=> (!met_o || !$stable(thr_i)));
endmodule

// File: rtl/srf_sfu_flag.sv
module srf_sfu_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic allow_i,
  input  logic clr_i,
  output logic pend_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               pend_q <= 1'b0;
    else if (clr_i)            pend_q <= 1'b0;
    else if (set_i && allow_i) pend_q <= 1'b1;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/srf_fsm.sv
module srf_fsm (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enable_i,
  input  logic               entry_i,
  input  logic               vblank_i,
  input  logic               change_i,
  input  logic               wake_seen_i,
  input  logic               idle_met_i,
  input  logic               sfu_pend_i,
  output srf_pkg::srf_state_e state_q_o,
  output srf_pkg::srf_state_e state_d_o,
  output logic               wake_req_o
);
  import srf_pkg::*;

  srf_state_e state_q, state_d;
  logic       wake_q;
  logic       leave_act;

  assign leave_act = !enable_i || !entry_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF:    if (enable_i) state_d = ST_IDLE;
      ST_IDLE: begin
        if (!enable_i)                  state_d = ST_OFF;
        else if (entry_i && idle_met_i) state_d = ST_ENTER;
      end
      // finishes regardless of enable: transitions are hardware owned
      ST_ENTER:  if (vblank_i && !change_i) state_d = ST_ACTIVE;
      ST_ACTIVE: begin
        if (leave_act || change_i) state_d = ST_EXIT;
        else if (sfu_pend_i)       state_d = ST_SINGLE;
      end
      ST_SINGLE: begin
        if (leave_act)     state_d = ST_EXIT;
        else if (vblank_i) state_d = ST_ACTIVE;
      end
      ST_EXIT:   if (wake_seen_i) state_d = ST_IDLE;
      default:   state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      wake_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wake_q  <= (state_d == ST_EXIT) && (state_q != ST_EXIT);
    end
  end

  assign state_q_o  = state_q;
  assign state_d_o  = state_d;
  assign wake_req_o = wake_q;

  assert_legal_code_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q inside {ST_OFF, ST_IDLE, ST_ENTER, ST_ACTIVE, ST_SINGLE, ST_EXIT});

  assert_off_exit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OFF) |=> (state_q inside {ST_OFF, ST_IDLE}));

  assert_enter_path_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ENTER) |=> (state_q inside {ST_ENTER, ST_ACTIVE}));

  assert_enter_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ENTER && !vblank_i) |=> (state_q == ST_ENTER));

  assert_change_exits_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACTIVE && change_i) |=> (state_q == ST_EXIT));

  assert_exit_waits_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EXIT && !wake_seen_i) |=> (state_q == ST_EXIT));

  assert_wake_in_exit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_req_o |-> (state_q == ST_EXIT));

  assert_wake_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_req_o |=> !wake_req_o);
endmodule

// File: rtl/srf_ctrl.sv
module srf_ctrl #(
  parameter int unsigned IDLE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              entry_i,
  input  logic              sfu_set_i,
  input  logic              vblank_i,
  input  logic              change_i,
  input  logic              wake_seen_i,
  input  logic [IDLE_W-1:0] idle_frames_i,
  output logic [2:0]        state_o,
  output logic              in_trans_o,
  output logic              link_down_o,
  output logic              active_o,
  output logic              sfu_pend_o,
  output logic              wake_req_o
);
  import srf_pkg::*;

  srf_state_e state_q, state_d;
  logic       idle_met, sfu_pend, sfu_clr;

  srf_idle_cnt #(.CNT_W(IDLE_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .count_en_i (state_q == ST_IDLE),
    .vblank_i   (vblank_i),
    .chg_i      (change_i),
    .thr_i      (idle_frames_i),
    .met_o      (idle_met)
  );

  // clear beats set: a request racing an exit is dropped
  assign sfu_clr = (state_d == ST_EXIT) || (state_d == ST_OFF) ||
                   (state_q == ST_SINGLE && state_d == ST_ACTIVE);

  srf_sfu_flag u_sfu (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (sfu_set_i),
    .allow_i (state_q != ST_OFF),
    .clr_i   (sfu_clr),
    .pend_o  (sfu_pend)
  );

  srf_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enable_i    (enable_i),
    .entry_i     (entry_i),
    .vblank_i    (vblank_i),
    .change_i    (change_i),
    .wake_seen_i (wake_seen_i),
    .idle_met_i  (idle_met),
    .sfu_pend_i  (sfu_pend),
    .state_q_o   (state_q),
    .state_d_o   (state_d),
    .wake_req_o  (wake_req_o)
  );

  assign state_o     = state_q;
  assign in_trans_o  = (state_q == ST_ENTER) || (state_q == ST_EXIT);
  assign link_down_o = (state_q == ST_ACTIVE);
  assign active_o    = (state_q == ST_ACTIVE) || (state_q == ST_SINGLE);
  assign sfu_pend_o  = sfu_pend;

  assert_single_has_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SINGLE) |-> sfu_pend_o);

  assert_single_return_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SINGLE && vblank_i && enable_i && entry_i) |=> (state_q == ST_ACTIVE && !sfu_pend_o));

  assert_exit_drops_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EXIT || state_q == ST_OFF) |-> !sfu_pend_o);
endmodule

// File: tb/sim_srf_ctrl.sv
module sim_srf_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 0, ent = 0, sfu = 0, vb = 0, chg = 0, wk = 0;
  logic [3:0] idle_cfg = 4'd3;
  logic [2:0] st;
  logic       trans, lnk, act, pend, wreq;
  int         n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  srf_ctrl #(.IDLE_W(4)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .entry_i(ent), .sfu_set_i(sfu),
    .vblank_i(vb), .change_i(chg), .wake_seen_i(wk), .idle_frames_i(idle_cfg),
    .state_o(st), .in_trans_o(trans), .link_down_o(lnk), .active_o(act),
    .sfu_pend_o(pend), .wake_req_o(wreq)
  );

  // {en, entry, sfu, vblank, change, wake, pad, exp_state}
  localparam logic [9:0] VEC [14] = '{
    10'b1_0_0_0_0_0_0_001, 10'b1_1_0_1_0_0_0_001, 10'b1_1_0_1_0_0_0_001,
    10'b1_1_0_1_0_0_0_001, 10'b1_1_0_1_0_0_0_001, 10'b1_1_0_1_0_0_0_001,
    10'b1_1_0_1_0_0_0_001, 10'b1_1_0_1_0_0_0_010, 10'b1_1_0_1_1_0_0_010,
    10'b1_1_0_1_0_0_0_011, 10'b1_1_0_0_0_0_0_011, 10'b1_1_0_0_1_0_0_101,
    10'b1_1_0_0_0_0_0_101, 10'b1_1_0_0_0_1_0_001
  };

  task automatic chk(input string req, input int actual, input int expected);
    n_chk++;
    if (actual != expected) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, actual, expected, $time);
    end
  endtask

  task automatic cyc(input logic e, input logic n, input logic s, input logic v,
                     input logic c, input logic w);
    en = e; ent = n; sfu = s; vb = v; chg = c; wk = w;
    @(posedge clk);
    #1;
    sfu = 0; vb = 0; chg = 0; wk = 0;
  endtask

  task automatic chk_state(input string req, input int exp_st);
    chk({req, " state"}, int'(st), exp_st);
    chk({req, " in_trans"}, int'(trans), int'(exp_st == 2 || exp_st == 5));
    chk({req, " link_down"}, int'(lnk), int'(exp_st == 3));
    chk({req, " active"}, int'(act), int'(exp_st == 3 || exp_st == 4));
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog: got 0 expected 1 (run completed)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk_state("R1 reset", 0);
    chk("R1 reset pend", int'(pend), 0);
    chk("R1 reset wake", int'(wreq), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R10: request ignored while off
    cyc(0, 0, 1, 0, 0, 0);
    chk("R10 set ignored in off", int'(pend), 0);

    // table walk: R2 enable, R3 clamp to 6 with cfg 3, R4 entry, R5 change exit, R6 wake
    for (int i = 0; i < 14; i++) begin
      cyc(VEC[i][9], VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4]);
      chk_state($sformatf("R2/R3/R4/R5/R6 vec %0d", i), int'(VEC[i][2:0]));
      if (i == 11) chk("R6 wake pulse on entry", int'(wreq), 1);
      if (i == 12) chk("R6 wake pulse one cycle", int'(wreq), 0);
    end

    // R3: change clears the idle count
    for (int k = 0; k < 4; k++) cyc(1, 1, 0, 1, 0, 0);
    cyc(1, 1, 0, 1, 1, 0);
    for (int k = 0; k < 6; k++) cyc(1, 1, 0, 1, 0, 0);
    chk_state("R3 count restarted", 1);
    cyc(1, 1, 0, 0, 0, 0);
    chk_state("R3 entry after reset count", 2);
    cyc(1, 1, 0, 1, 0, 0);
    chk_state("R4 to active", 3);

    // R7 single-frame update
    cyc(1, 1, 1, 0, 0, 0);
    chk("R7 flag set", int'(pend), 1);
    chk_state("R7 still active", 3);
    cyc(1, 1, 0, 0, 0, 0);
    chk_state("R7 single update", 4);
    cyc(1, 1, 0, 0, 1, 0);
    chk_state("R7 change ignored in 4", 4);
    cyc(1, 1, 0, 1, 0, 0);
    chk_state("R7 back to active", 3);
    chk("R7 flag self-clear", int'(pend), 0);

    // R9 collision: request and change together in active
    cyc(1, 1, 1, 0, 1, 0);
    chk_state("R9 exit wins", 5);
    chk("R9 flag low", int'(pend), 0);
    chk("R9 wake pulse", int'(wreq), 1);
    cyc(1, 1, 0, 0, 0, 1);
    chk_state("R6 back to inactive", 1);

    // R8: enable dropped during entry
    for (int k = 0; k < 6; k++) cyc(1, 1, 0, 1, 0, 0);
    cyc(1, 1, 1, 0, 0, 0);
    chk_state("R8 entering", 2);
    cyc(0, 1, 0, 0, 0, 0);
    chk_state("R8 entry not aborted", 2);
    cyc(0, 1, 0, 1, 0, 0);
    chk_state("R8 entry completes", 3);
    cyc(0, 1, 0, 0, 0, 0);
    chk_state("R8 exit after entry", 5);
    chk("R10 flag cleared on exit", int'(pend), 0);
    cyc(0, 1, 0, 0, 0, 0);
    chk_state("R8 exit waits wake", 5);
    cyc(0, 1, 0, 0, 0, 1);
    chk_state("R8 inactive first", 1);
    cyc(0, 1, 0, 0, 0, 0);
    chk_state("R2 off", 0);

    // R3 threshold above the minimum, R5 entry request dropped
    idle_cfg = 4'd9;
    cyc(1, 1, 0, 0, 0, 0);
    for (int k = 0; k < 9; k++) cyc(1, 1, 0, 1, 0, 0);
    chk_state("R3 nine frames not yet", 1);
    cyc(1, 1, 0, 0, 0, 0);
    chk_state("R3 nine frames met", 2);
    cyc(1, 1, 0, 1, 0, 0);
    chk_state("R4 active again", 3);
    cyc(1, 0, 0, 0, 0, 0);
    chk_state("R5 entry dropped exits", 5);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule